// File: doc/BRIEF.md
# Eight-Level Nesting Interrupt Controller

This block decides when a small stack-based processor core should break into its running program. There are eight request lines, one per level. Each line has a fixed priority, and level 7 ranks highest. Requests are caught once per machine cycle in an 8-bit pending register. Catching happens only on the machine-cycle strobe, and only when the current instruction is not an I/O instruction. A second 8-bit register, the active register, records which service routines are currently nested.

When the core reports that it can accept a break, the controller may take a pending level. This requires the global enable flag to be set and the level to rank above every level already in service. A take is a one-cycle acknowledge pulse. In the same cycle the controller supplies that level's routine address and asks the core to push its program counter.

A return strobe ends the innermost routine. That routine is the highest set bit of the active register. Its active bit and its pending bit are cleared on the same clock edge.

A level's pending bit stays set until its routine returns, so any new request on that level in the meantime merges into the bit already set. While the enable flag is clear, requests keep collecting in the pending register and are serviced once the flag is set again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous active-high reset, pending, active, int_take, push_pc and vector are all zero.
- R2: On a clock edge where mc_strobe is 1 and io_cycle is 0, pending becomes the OR of its old value and irq_req.
- R3: On an edge where mc_strobe is 0 or io_cycle is 1, irq_req has no effect on pending.
- R4: A request on a level whose pending bit is already set leaves pending unchanged. While ien_flag is 0 no level is taken, and requests keep collecting in pending.
- R5: A pending level is eligible only if it is higher than every level set in active. Among eligible levels the highest-numbered one is taken, so level 7 has the top priority.
- R6: A level is taken on an edge where ien_flag and ack_ready are both 1, rti is 0 and some level is eligible. int_take and push_pc are then 1 for exactly the following cycle, and the taken level's bit is set in active.
- R7: On a take of level L, vector becomes VEC_BASE + L*VEC_STRIDE (defaults 8'h40 and 8, so 0x40 + 8*L). It then holds that value until the next take.
- R8: On an edge where rti is 1, the highest set bit of active and the same bit of pending are cleared. If active is zero, rti has no effect.
- R9: When rti and a sampling edge coincide, the return clears bits first and the sampled requests are ORed in afterwards, so a request on the returning level survives in pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | 8 | Request lines, bit n is level n |
| mc_strobe | input | 1 | One-clock pulse marking a machine-cycle sample point |
| io_cycle | input | 1 | Current instruction is an I/O instruction; blocks sampling |
| ien_flag | input | 1 | Global interrupt enable flag from the core |
| ack_ready | input | 1 | Core can run an acknowledge cycle on this edge |
| rti | input | 1 | Return-from-interrupt strobe |
| int_take | output | 1 | Acknowledge pulse: a level is being taken |
| vector | output | 8 | Service-routine address of the last taken level |
| push_pc | output | 1 | Request to save the program counter on the return stack |
| pending | output | 8 | Pending register |
| active | output | 8 | Active register |

## Verification
Both state registers are outputs, so a wrong bit in pending or active is visible at the ports one clock after the edge that caused it. A fault in eligibility or priority shows in the next take. A wrong choice of level appears as an unexpected vector and active bit, and a missed take appears as a cycle where int_take stays low although an eligible level is waiting. A fault in return handling shows one cycle after rti, as the wrong bit or no bit removed from both registers.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned MAX_LVL = 32;

  // index of the most significant set bit, 0 when none
  function automatic int unsigned top_bit(input logic [MAX_LVL-1:0] v);
    int unsigned idx;
    idx = 0;
    for (int unsigned i = 0; i < MAX_LVL; i++) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction
endpackage

// File: rtl/irq_latch.sv
module irq_latch #(
  parameter int unsigned N_LVL = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_en,
  input  logic [N_LVL-1:0] req,
  input  logic [N_LVL-1:0] clr_mask,
  output logic [N_LVL-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_mask) | (sample_en ? req : '0);
  end

  // R3
  hold_no_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (!sample_en && clr_mask == '0) |=> $stable(pend));
  // R2
  sample_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_en && clr_mask == '0) |=> ((pend & $past(req)) == $past(req)));
endmodule

// File: rtl/irq_active.sv
module irq_active
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_LVL = 8,
  localparam int unsigned IDX_W = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rti,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  output logic [N_LVL-1:0] act,
  output logic [N_LVL-1:0] clr_mask
);
  logic [IDX_W-1:0] act_top;

  always_comb begin
    act_top  = IDX_W'(top_bit(MAX_LVL'(act)));
    clr_mask = (rti && (act != '0)) ? (N_LVL'(1) << act_top) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) act <= '0;
    else     act <= (act & ~clr_mask) | (set_en ? (N_LVL'(1) << set_idx) : '0);
  end

  // R8
  rti_pops_one_chk: assert property (@(posedge clk) disable iff (rst)
    (rti && act != '0 && !set_en) |=> ($countones(act) + 1 == $countones($past(act))));
  // R6
  take_adds_one_chk: assert property (@(posedge clk) disable iff (rst)
    (set_en && !rti) |=> ($countones(act) == $countones($past(act)) + 1));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_LVL = 8,
  localparam int unsigned IDX_W = $clog2(N_LVL)
) (
  input  logic [N_LVL-1:0] pend,
  input  logic [N_LVL-1:0] act,
  output logic             grant_valid,
  output logic [IDX_W-1:0] grant_idx
);
  logic [IDX_W-1:0] act_top;
  logic             act_any;
  logic [N_LVL-1:0] elig;

  assign act_any = |act;
  assign act_top = IDX_W'(top_bit(MAX_LVL'(act)));

  for (genvar g = 0; g < N_LVL; g++) begin : g_elig
    assign elig[g] = pend[g] & (!act_any || (act_top < IDX_W'(g)));
  end

  assign grant_valid = |elig;
  assign grant_idx   = IDX_W'(top_bit(MAX_LVL'(elig)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned N_LVL      = 8,
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned VEC_BASE   = 8'h40,
  parameter int unsigned VEC_STRIDE = 8,
  localparam int unsigned IDX_W     = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_LVL-1:0] irq_req,
  input  logic             mc_strobe,
  input  logic             io_cycle,
  input  logic             ien_flag,
  input  logic             ack_ready,
  input  logic             rti,
  output logic             int_take,
  output logic [VEC_W-1:0] vector,
  output logic             push_pc,
  output logic [N_LVL-1:0] pending,
  output logic [N_LVL-1:0] active
);
  logic             sample_en;
  logic [N_LVL-1:0] clr_mask;
  logic             grant_valid;
  logic [IDX_W-1:0] grant_idx;
  logic             take;

  assign sample_en = mc_strobe && !io_cycle;
  assign take      = ien_flag && ack_ready && !rti && grant_valid;

  irq_latch #(.N_LVL(N_LVL)) u_latch (
    .clk(clk), .rst(rst), .sample_en(sample_en), .req(irq_req),
    .clr_mask(clr_mask), .pend(pending)
  );

  irq_active #(.N_LVL(N_LVL)) u_active (
    .clk(clk), .rst(rst), .rti(rti), .set_en(take), .set_idx(grant_idx),
    .act(active), .clr_mask(clr_mask)
  );

  irq_arbiter #(.N_LVL(N_LVL)) u_arb (
    .pend(pending), .act(active),
    .grant_valid(grant_valid), .grant_idx(grant_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_take <= 1'b0;
      push_pc  <= 1'b0;
      vector   <= '0;
    end else begin
      int_take <= take;
      push_pc  <= take;
      if (take) vector <= VEC_W'(VEC_BASE + int'(grant_idx) * VEC_STRIDE);
    end
  end

  // R5
  active_in_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (active & ~pending) == '0);
  // R6
  take_gated_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(int_take) |-> $past(ien_flag && ack_ready && !rti));
  // R6
  push_with_take_chk: assert property (@(posedge clk) disable iff (rst)
    push_pc == int_take);
  // R7
  vector_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !int_take |-> $stable(vector));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYC   = 4000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_req = '0;
  logic       mc_strobe = 1'b0, io_cycle = 1'b0, ien_flag = 1'b0;
  logic       ack_ready = 1'b0, rti = 1'b0;
  logic       int_take, push_pc;
  logic [7:0] vector, pending, active;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .irq_req(irq_req), .mc_strobe(mc_strobe),
    .io_cycle(io_cycle), .ien_flag(ien_flag), .ack_ready(ack_ready), .rti(rti),
    .int_take(int_take), .vector(vector), .push_pc(push_pc),
    .pending(pending), .active(active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model built from the requirements
  logic [7:0] m_pend, m_act, m_vec;
  logic       m_take;

  function automatic int msb8(input logic [7:0] v);
    int r = -1;
    for (int i = 0; i < 8; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic [7:0] eligible(input logic [7:0] p, input logic [7:0] a);
    logic [7:0] e;
    int top = msb8(a);
    for (int i = 0; i < 8; i++) e[i] = p[i] && (i > top);
    return e;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pend <= '0; m_act <= '0; m_vec <= '0; m_take <= 1'b0;
    end else begin
      logic [7:0] clr, e, smp;
      logic       tk;
      int         lv;
      clr = (rti && m_act != 0) ? (8'd1 << msb8(m_act)) : 8'd0;
      e   = eligible(m_pend, m_act);
      tk  = ien_flag && ack_ready && !rti && (e != 0);
      lv  = msb8(e);
      smp = (mc_strobe && !io_cycle) ? irq_req : 8'd0;
      m_pend <= (m_pend & ~clr) | smp;
      m_act  <= (m_act & ~clr) | (tk ? (8'd1 << lv) : 8'd0);
      m_take <= tk;
      if (tk) m_vec <= 8'h40 + 8'(lv * 8);
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // drive at a falling edge, then wait until the next falling edge
  task automatic step(input logic [7:0] rq, input logic mc, input logic io,
                      input logic en, input logic ak, input logic rt);
    @(negedge clk);
    irq_req = rq; mc_strobe = mc; io_cycle = io;
    ien_flag = en; ack_ready = ak; rti = rt;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1", "pending", pending, 8'h00);
    chk("R1", "active", active, 8'h00);
    chk("R1", "int_take", {7'd0, int_take}, 8'h00);
    chk("R1", "push_pc", {7'd0, push_pc}, 8'h00);
    chk("R1", "vector", vector, 8'h00);

    // R3: no strobe, then strobe during an I/O cycle
    step(8'hFF, 0, 0, 0, 0, 0);
    chk("R3", "pending no strobe", pending, 8'h00);
    step(8'hFF, 1, 1, 0, 0, 0);
    chk("R3", "pending io cycle", pending, 8'h00);

    // R2 then R4: sample, merge, deferral while disabled
    step(8'h05, 1, 0, 0, 0, 0);
    chk("R2", "pending", pending, 8'h05);
    step(8'h01, 1, 0, 0, 1, 0);
    chk("R4", "pending merge", pending, 8'h05);
    chk("R4", "int_take disabled", {7'd0, int_take}, 8'h00);
    chk("R4", "active disabled", active, 8'h00);

    // R6, R7: take level 2
    step(8'h00, 0, 0, 1, 1, 0);
    chk("R6", "int_take", {7'd0, int_take}, 8'h01);
    chk("R6", "push_pc", {7'd0, push_pc}, 8'h01);
    chk("R6", "active", active, 8'h04);
    chk("R7", "vector lvl2", vector, 8'h50);

    // R5: level 0 below active level 2 waits; vector held
    step(8'h00, 0, 0, 1, 1, 0);
    chk("R5", "int_take blocked", {7'd0, int_take}, 8'h00);
    chk("R7", "vector held", vector, 8'h50);

    // R5: level 7 nests above level 2
    step(8'h80, 1, 0, 1, 1, 0);
    chk("R2", "pending lvl7", pending, 8'h85);
    chk("R6", "int_take one cycle", {7'd0, int_take}, 8'h00);
    step(8'h00, 0, 0, 1, 1, 0);
    chk("R5", "active nested", active, 8'h84);
    chk("R7", "vector lvl7", vector, 8'h78);

    // R8: return from level 7
    step(8'h00, 0, 0, 1, 0, 1);
    chk("R8", "active", active, 8'h04);
    chk("R8", "pending", pending, 8'h05);

    // R9: return from level 2 while level 2 requests again
    step(8'h04, 1, 0, 1, 0, 1);
    chk("R9", "active", active, 8'h00);
    chk("R9", "pending", pending, 8'h05);

    // R8: rti with nothing active
    step(8'h00, 0, 0, 1, 0, 1);
    chk("R8", "pending empty rti", pending, 8'h05);
    chk("R8", "active empty rti", active, 8'h00);

    // R5: level 2 wins over level 0
    step(8'h00, 0, 0, 1, 1, 0);
    chk("R5", "vector lvl2 again", vector, 8'h50);
    step(8'h00, 0, 0, 1, 0, 1);
    step(8'h00, 0, 0, 1, 1, 0);
    chk("R7", "vector lvl0", vector, 8'h40);
    chk("R6", "active lvl0", active, 8'h01);

    // random phase against the model
    for (int c = 0; c < RAND_CYC; c++) begin
      @(negedge clk);
      chk("R2", "pending rnd", pending, m_pend);
      chk("R5", "active rnd", active, m_act);
      chk("R6", "int_take rnd", {7'd0, int_take}, {7'd0, m_take});
      chk("R6", "push_pc rnd", {7'd0, push_pc}, {7'd0, m_take});
      chk("R7", "vector rnd", vector, m_vec);
      irq_req   = ($urandom % 4 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      mc_strobe = c[0];
      io_cycle  = ($urandom % 5 == 0);
      ien_flag  = ($urandom % 6 != 0);
      ack_ready = ($urandom % 3 != 0);
      rti       = ($urandom % 6 == 0);
    end
    finish_run();
  end
endmodule